// File: doc/BRIEF.md
# Three-Wire Serial Word Loader

This block is a bus master for a three-wire programming port made of a serial clock, a serial data line and a latch strobe. A host gives it a 24-bit control word through a valid/ready handshake. The block shifts the word out most significant bit first, with one bit per serial clock period. Once the last bit is sent, it raises the latch strobe so that the receiving device moves the word into the target register. That register is picked by the two least significant bits, which go out last. The block never reads anything back and does not look at the contents of the word.

The serial pins are timed from a fast system clock. Each minimum interval is a parameter that gives a count of system-clock cycles, rounded up, and any value below 1 is raised to 1. The intervals are: serial clock high, serial clock low, data setup, data hold, clock-to-latch, latch pulse width, and latch-low time before the next frame. The data line changes only while the serial clock is low, at the midpoint of the low phase or later. This leaves a setup margin before the rising edge and a hold margin after it.

The control state machine has six states. `ST_IDLE` waits for a word, with ready high. `ST_LOW` and `ST_HIGH` are the two phases of each serial clock period. `ST_GAP` is the clock-to-latch wait. `ST_LATCH` holds the strobe high. `ST_RECOV` holds the strobe low before ready returns. The transitions are:
- `ST_IDLE`→`ST_LOW` on accept.
- `ST_LOW`→`ST_HIGH` when the low interval ends.
- `ST_HIGH`→`ST_LOW` when the high interval ends and bits remain.
- `ST_HIGH`→`ST_GAP` when the high interval of bit 0 ends.
- `ST_GAP`→`ST_LATCH`, `ST_LATCH`→`ST_RECOV` and `ST_RECOV`→`ST_IDLE`, each when its interval ends.

Top module: `serial_word_loader`

## Requirements
- R1: While reset is asserted, `ser_clk`, `ser_data`, `ser_le`, `done` and `in_ready` are all 0. In the first cycle after reset is released, `in_ready` is 1 and the serial pins stay low.
- R2: A word is taken when `in_valid` and `in_ready` are both 1 at a clock edge. `in_ready` is 0 from the next cycle on and stays 0 while `ser_clk` or `ser_le` is high.
- R3: Each frame carries exactly 24 rising edges of `ser_clk` before `ser_le` rises. The bits sampled on those edges are the accepted word, in order from bit 23 down to bit 0.
- R4: Each `ser_clk` high phase lasts exactly max(CLK_HI_CYC, DATA_HOLD_CYC) cycles. Each low phase between two bits of a frame lasts exactly max(CLK_LO_CYC, 2·DATA_SETUP_CYC) cycles.
- R5: `ser_data` never changes while `ser_clk` is high. It changes only at a low-phase cycle index of at least half the low phase length, and at least DATA_SETUP_CYC cycles before the next rising edge.
- R6: `ser_le` rises exactly CLK2LE_CYC cycles after the last fall of `ser_clk`, and it is never high at the same time as `ser_clk`.
- R7: `ser_le` stays high for exactly LE_HI_CYC cycles.
- R8: `done` is 1 for one cycle, in the cycle in which `ser_le` falls, and at no other time.
- R9: After `ser_le` falls, `in_ready` stays 0 for exactly LE_SETUP_CYC cycles and is then 1.
- R10: The last two bits sent in a frame are bits 1 and 0 of the word, the register-select bits. They are sent in that order, just before the latch.
- R11: While `in_ready` is 0, the block ignores `in_valid` and `in_word`. The frame in flight carries the word that was accepted, and no other frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a word |
| in_word | input | WORD_W | Word to send |
| in_ready | output | 1 | Block can accept a word |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, idles low |
| ser_le | output | 1 | Latch strobe, idles low |
| done | output | 1 | One-cycle pulse as the latch strobe falls |

## Verification
The checker watches several rules on every cycle:
- the latch strobe and the serial clock are never high together;
- data stays still while the clock is high;
- ready is low while the clock or the strobe is high, and it drops after an accept;
- `done` comes exactly when the strobe falls;
- each high pulse of the clock and of the strobe meets its minimum width.

Other rules show only in the bench's scenarios, where a slave model captures each frame and measures its phases:
- the captured words match, bit order included;
- each phase has the exact length it should;
- each data change falls in the allowed part of the low phase;
- the clock-to-latch gap, the ready recovery delay and the handling of a valid held high during a busy frame are correct.

// File: rtl/swl_pkg.sv
`timescale 1ns/1ps
package swl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_LATCH,
        ST_RECOV
    } swl_state_e;

    function automatic int unsigned swl_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swl_phase_timer.sv
`timescale 1ns/1ps
// Counts cycles spent in the current state; restart zeroes it.
module swl_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != {CNT_W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/swl_shifter.sv
`timescale 1ns/1ps
// Holds the word in flight, drives the data pin and tracks the bit position.
module swl_shifter #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              emit,
    input  logic              bit_end,
    input  logic              clear,
    output logic              sdata,
    output logic              last_bit
);

    localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
            sdata <= 1'b0;
        end else begin
            if (load) begin
                sh_q  <= word;
                idx_q <= '0;
            end else begin
                if (emit) begin
                    sh_q <= {sh_q[WORD_W-2:0], 1'b0};
                end
                if (bit_end) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (emit) begin
                sdata <= sh_q[WORD_W-1];
            end else if (clear) begin
                sdata <= 1'b0;
            end
        end
    end

    assign last_bit = (idx_q == IDX_LAST);

endmodule

// File: rtl/serial_word_loader.sv
`timescale 1ns/1ps
module serial_word_loader #(
    parameter int unsigned WORD_W         = 24,
    parameter int unsigned CLK_HI_CYC     = 7,
    parameter int unsigned CLK_LO_CYC     = 7,
    parameter int unsigned DATA_SETUP_CYC = 3,
    parameter int unsigned DATA_HOLD_CYC  = 3,
    parameter int unsigned CLK2LE_CYC     = 3,
    parameter int unsigned LE_HI_CYC      = 5,
    parameter int unsigned LE_SETUP_CYC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le,
    output logic              done
);

    import swl_pkg::*;

    // every interval is at least one cycle
    localparam int unsigned SU_E   = swl_max(DATA_SETUP_CYC, 1);
    localparam int unsigned LO_E   = swl_max(swl_max(CLK_LO_CYC, 1), 2 * SU_E);
    localparam int unsigned HI_E   = swl_max(swl_max(CLK_HI_CYC, 1), DATA_HOLD_CYC);
    localparam int unsigned GAP_E  = swl_max(CLK2LE_CYC, 1);
    localparam int unsigned LEH_E  = swl_max(LE_HI_CYC, 1);
    localparam int unsigned LES_E  = swl_max(LE_SETUP_CYC, 1);
    localparam int unsigned CHG_AT = LO_E - SU_E;
    localparam int unsigned CNT_MAX =
        swl_max(swl_max(LO_E, HI_E), swl_max(GAP_E, swl_max(LEH_E, LES_E)));
    localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] LO_END  = CNT_W'(LO_E - 1);
    localparam logic [CNT_W-1:0] HI_END  = CNT_W'(HI_E - 1);
    localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_E - 1);
    localparam logic [CNT_W-1:0] LEH_END = CNT_W'(LEH_E - 1);
    localparam logic [CNT_W-1:0] LES_END = CNT_W'(LES_E - 1);
    localparam logic [CNT_W-1:0] CHG_END = CNT_W'(CHG_AT - 1);

    swl_state_e       state_q, state_n;
    logic [CNT_W-1:0] tcount;
    logic             accept, emit, bit_end, clear, last_bit;

    assign accept  = in_valid && in_ready;
    assign emit    = (state_q == ST_LOW)  && (tcount == CHG_END);
    assign bit_end = (state_q == ST_HIGH) && (tcount == HI_END);
    assign clear   = (state_q == ST_LATCH) && (state_n == ST_RECOV);

    swl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_n != state_q),
        .count   (tcount)
    );

    swl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .word     (in_word),
        .emit     (emit),
        .bit_end  (bit_end),
        .clear    (clear),
        .sdata    (ser_data),
        .last_bit (last_bit)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)             state_n = ST_LOW;
            ST_LOW:   if (tcount == LO_END)   state_n = ST_HIGH;
            ST_HIGH:  if (tcount == HI_END)   state_n = last_bit ? ST_GAP : ST_LOW;
            ST_GAP:   if (tcount == GAP_END)  state_n = ST_LATCH;
            ST_LATCH: if (tcount == LEH_END)  state_n = ST_RECOV;
            ST_RECOV: if (tcount == LES_END)  state_n = ST_IDLE;
            default:                          state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // registered pin decode, aligned with the state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_clk  <= 1'b0;
            ser_le   <= 1'b0;
            in_ready <= 1'b0;
            done     <= 1'b0;
        end else begin
            ser_clk  <= (state_n == ST_HIGH);
            ser_le   <= (state_n == ST_LATCH);
            in_ready <= (state_n == ST_IDLE);
            done     <= clear;
        end
    end

endmodule

// File: rtl/swl_checker.sv
`timescale 1ns/1ps
module swl_checker #(
    parameter int unsigned CLK_HI_CYC = 7,
    parameter int unsigned LE_HI_CYC  = 5
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le,
    input logic done
);

    logic [15:0] hi_run, le_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            le_run <= '0;
        end else begin
            hi_run <= ser_clk ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : 16'd0;
            le_run <= ser_le  ? ((le_run == 16'hFFFF) ? le_run : le_run + 16'd1) : 16'd0;
        end
    end

    p_le_excl_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_clk && ser_le));

    p_data_still_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data));

    p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk || ser_le) |-> !in_ready);

    p_accept_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(ser_le));

    p_fall_gives_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_le) |-> done);

    p_clk_hi_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (hi_run >= 16'(CLK_HI_CYC)));

    p_le_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_le) |-> (le_run >= 16'(LE_HI_CYC)));

endmodule

bind serial_word_loader swl_checker #(
    .CLK_HI_CYC (CLK_HI_CYC),
    .LE_HI_CYC  (LE_HI_CYC)
) u_swl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_le   (ser_le),
    .done     (done)
);

// File: tb/tb_serial_word_loader.sv
`timescale 1ns/1ps
module tb_serial_word_loader;

    localparam int W   = 24;
    localparam int HI  = 7;
    localparam int LO  = 7;
    localparam int SU  = 3;
    localparam int HO  = 3;
    localparam int C2L = 3;
    localparam int LEH = 5;
    localparam int LES = 5;
    localparam int LO_E = (LO > 2 * SU) ? LO : 2 * SU;
    localparam int HI_E = (HI > HO) ? HI : HO;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_word = '0;
    logic         in_ready, ser_clk, ser_data, ser_le, done;

    serial_word_loader #(
        .WORD_W(W), .CLK_HI_CYC(HI), .CLK_LO_CYC(LO), .DATA_SETUP_CYC(SU),
        .DATA_HOLD_CYC(HO), .CLK2LE_CYC(C2L), .LE_HI_CYC(LEH), .LE_SETUP_CYC(LES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .done(done)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // slave model and scoreboard monitor
    logic p_clk = 0, p_data = 0, p_le = 0;
    int hi_run = 0, lo_run = 0, le_run = 0, gap_cnt = 0, since_chg = 0, bits = 0;
    int v_hi = 0, v_lo = 0, v_chg = 0, v_setup = 0, v_lec = 0, frames = 0;
    bit waiting = 0;
    logic [W-1:0] cap = '0, last_cap = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_clk = 0; p_data = 0; p_le = 0; lo_run = 0; hi_run = 0; bits = 0;
        end else begin
            logic [W-1:0] e;
            if (ser_clk) hi_run = p_clk ? hi_run + 1 : 1;
            else         lo_run = p_clk ? 1 : lo_run + 1;
            if (ser_clk && !p_clk) begin
                if (bits > 0 && lo_run != LO_E) v_lo++;
                if (since_chg < SU) v_setup++;
                cap = {cap[W-2:0], ser_data};
                bits++;
            end
            if (!ser_clk && p_clk && hi_run != HI_E) v_hi++;
            if (ser_data != p_data) begin
                if (ser_clk) v_chg++;
                else if (lo_run - 1 < LO_E / 2) v_chg++;
                since_chg = 0;
            end
            since_chg++;
            if (ser_le && ser_clk) v_lec++;
            if (ser_le && !p_le) begin
                chk(lo_run - 1 == C2L, "R6 clk-to-latch gap", lo_run - 1, C2L);
                chk(bits == W, "R3 rising edges per frame", bits, W);
                le_run = 1;
            end else if (ser_le) begin
                le_run++;
            end
            if (!ser_le && p_le) begin
                chk(le_run == LEH, "R7 latch width", le_run, LEH);
                chk(done == 1'b1, "R8 done at latch fall", done, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected frame", cap, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cap == e, "R3 captured word", cap, e);
                    chk(cap[1:0] == e[1:0], "R10 register select bits", cap[1:0], e[1:0]);
                end
                chk(v_hi == 0, "R4 high phase length", v_hi, 0);
                chk(v_lo == 0, "R4 low phase length", v_lo, 0);
                chk(v_chg == 0, "R5 data change position", v_chg, 0);
                chk(v_setup == 0, "R5 data setup", v_setup, 0);
                chk(v_lec == 0, "R6 latch overlaps clock", v_lec, 0);
                last_cap = cap;
                v_hi = 0; v_lo = 0; v_chg = 0; v_setup = 0; v_lec = 0; bits = 0;
                waiting = 1; gap_cnt = 0; frames++;
            end else if (done) begin
                chk(1'b0, "R8 stray done", 1, 0);
            end
            if (waiting) begin
                if (in_ready) begin
                    chk(gap_cnt == LES, "R9 ready recovery", gap_cnt, LES);
                    waiting = 0;
                end else begin
                    gap_cnt++;
                end
            end
            p_clk = ser_clk; p_data = ser_data; p_le = ser_le;
        end
    end

    // driver
    task automatic send(input logic [W-1:0] w, input bit junk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        exp_q.push_back(w);
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready drops after accept", in_ready, 0);
        if (junk) begin
            in_word = ~w;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                chk(in_ready == 1'b0, "R11 ready held low while busy", in_ready, 0);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({ser_clk, ser_data, ser_le, done, in_ready} == 5'b0, "R1 outputs in reset",
            {ser_clk, ser_data, ser_le, done, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk({ser_clk, ser_data, ser_le} == 3'b0, "R1 idle pins low",
            {ser_clk, ser_data, ser_le}, 0);

        send(24'hA5A5A6, 1'b0);
        send(24'hFFFFFF, 1'b0);
        send(24'h000000, 1'b0);
        send(24'h800001, 1'b0);
        send(24'h5A5A59, 1'b0);
        send(24'h3C3C32, 1'b1);

        @(negedge clk);
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        chk(last_cap == 24'h3C3C32, "R11 busy-time word ignored", last_cap, 24'h3C3C32);
        chk(frames == 6, "R11 frame count", frames, 6);
        repeat (20) @(negedge clk);
        chk({ser_clk, ser_data, ser_le} == 3'b0, "R1 pins low between frames",
            {ser_clk, ser_data, ser_le}, 0);
        summary();
        $finish;
    end

endmodule